// File: doc/BRIEF.md
# Quad-Rate Burst-of-Four Synchronous SRAM

This block is a cycle-accurate, synthesizable model of a synchronous SRAM with a write-data port and a read-data port that are separate from each other. One address bus serves both directions. Every command moves a fixed burst of four words, two words per clock cycle, so one read burst and one write burst can run at the same time. Time runs on a single clock at the data rate. An internal phase flag marks which edges stand for the positive input clock (commands are sampled only there) and which stand for its complement.

The address names a four-word group, and the burst walks the two low word-address bits 0, 1, 2, 3. Write data is late: it arrives over the four edges that begin one full clock after the command. Read data leaves over the same relative window. A read whose word is being written on the same edge returns the new lanes and the old ones for lanes that are masked. A strobe toggles with each word driven, so a receiver can follow the read data.

Top module: `qdr4_sram`

## Requirements
- R1: `kphase` is 1 in the first cycle after reset and inverts on every clock edge. Commands are sampled only at edges where `kphase` was 1 (K edges); `rd_n`/`wr_n` low at other edges has no effect.
- R2: A read accepted at K edge T (`rd_n` low) drives words at word address {addr, b}, b = 0..3, on `dout` with `dout_en` high after edges T+2, T+3, T+4 and T+5.
- R3: A write accepted at K edge T (`wr_n` low) stores `din` sampled at edges T+2, T+3, T+4, T+5 into word addresses {addr, 0..3} in that order.
- R4: `bw_n[i]` low, sampled with each write word, enables storage of bits 9i+8 down to 9i of that word. Lanes whose bit is high keep their old contents.
- R5: A read (write) request at the K edge two edges after an accepted read (write) is ignored. A request four edges after it is accepted.
- R6: `din` and `bw_n` at edges that carry no write word change no stored data.
- R7: Reads (writes) accepted every fourth edge give data on every edge with no gap.
- R8: After an edge that carries no read word, `dout_en` is 0 and `dout` is all zeros.
- R9: A read word taken at the same edge as a write word to the same word address returns the newly written lanes merged with the stored, masked lanes.
- R10: `echo` inverts after every edge that drives a read word and holds otherwise.
- R11: During and right after reset, `dout_en` and `echo` are 0 and `dout` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Data-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_n | input | 1 | Read request, active low, sampled at K edges |
| wr_n | input | 1 | Write request, active low, sampled at K edges |
| addr | input | AW | Four-word group address shared by reads and writes |
| din | input | 9*LANES | Write data word |
| bw_n | input | LANES | Per-lane write enables, active low |
| kphase | output | 1 | High when the next edge is a K edge |
| dout | output | 9*LANES | Read data word, zero when idle |
| dout_en | output | 1 | Read word valid / output drive enable |
| echo | output | 1 | Toggles with each read word driven |

## Verification
If a burst beat counter is wrong, the words come out rotated or repeated within a burst. This shows on `dout` within four edges of the launch. If a pending-command flag sticks, the next read or write is dropped. That shows one full clock later as a missing `dout_en` or as stale data on a later read-back. Faults in forwarding or in the lane masks only show when a read and a write meet on the same word at the same edge, so the bench forces that case on purpose and also reaches it in a long random run against a reference array.

// File: rtl/qdr4_pkg.sv
package qdr4_pkg;
  localparam int BURST_LEN = 4;
  localparam int BEAT_W    = 2;
  localparam int LANE_W    = 9;

  typedef enum logic {
    PH_KBAR = 1'b0,
    PH_K    = 1'b1
  } phase_e;
endpackage

// File: rtl/qdr4_burst_seq.sv
module qdr4_burst_seq #(
  parameter int AW = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             k_edge,
  input  logic                             req_n,
  input  logic [AW-1:0]                    addr,
  output logic                             accept,
  output logic                             fire,
  output logic [AW+qdr4_pkg::BEAT_W-1:0]   word_addr
);
  import qdr4_pkg::*;
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);

  logic              q_v;
  logic [AW-1:0]     q_addr;
  logic [AW-1:0]     base;
  logic [BEAT_W-1:0] beat;
  logic              act;
  logic              launch;

  assign accept    = k_edge & ~req_n & ~q_v;
  assign launch    = k_edge & q_v;
  assign fire      = launch | act;
  assign word_addr = launch ? {q_addr, {BEAT_W{1'b0}}} : {base, beat};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_v    <= 1'b0;
      q_addr <= '0;
      base   <= '0;
      beat   <= '0;
      act    <= 1'b0;
    end else begin
      if (accept) begin
        q_v    <= 1'b1;
        q_addr <= addr;
      end else if (launch) begin
        q_v <= 1'b0;
      end
      if (launch) begin
        base <= q_addr;
        beat <= BEAT_W'(1);
        act  <= 1'b1;
      end else if (act) begin
        beat <= beat + BEAT_W'(1);
        if (beat == LAST_BEAT) act <= 1'b0;
      end
    end
  end

  AST_NO_ACCEPT_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !$past(accept, 2)); // R5
  AST_FIRST_BEAT_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fire) |-> $past(accept, 2)); // R3
  AST_BEATS_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> $past(fire)); // R7
endmodule

// File: rtl/qdr4_mem.sv
module qdr4_mem #(
  parameter int WAW   = 6,
  parameter int LANES = 2
) (
  input  logic                                 clk,
  input  logic                                 we,
  input  logic [WAW-1:0]                       waddr,
  input  logic [LANES*qdr4_pkg::LANE_W-1:0]    wdata,
  input  logic [LANES-1:0]                     wbyte_n,
  input  logic [WAW-1:0]                       raddr,
  output logic [LANES*qdr4_pkg::LANE_W-1:0]    rdata
);
  import qdr4_pkg::*;
  localparam int DEPTH = 1 << WAW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];
    always_ff @(posedge clk) begin
      if (we && !wbyte_n[g]) bank[waddr] <= wdata[g*LANE_W +: LANE_W];
    end
    assign rdata[g*LANE_W +: LANE_W] = bank[raddr];
  end
endmodule

// File: rtl/qdr4_rd_out.sv
module qdr4_rd_out #(
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [DW-1:0] word,
  output logic [DW-1:0] dout,
  output logic          dout_en,
  output logic          echo
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout    <= '0;
      dout_en <= 1'b0;
      echo    <= 1'b0;
    end else begin
      dout    <= fire ? word : '0;
      dout_en <= fire;
      if (fire) echo <= ~echo;
    end
  end
endmodule

// File: rtl/qdr4_sram.sv
module qdr4_sram #(
  parameter int AW    = 4,
  parameter int LANES = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              rd_n,
  input  logic                              wr_n,
  input  logic [AW-1:0]                     addr,
  input  logic [LANES*qdr4_pkg::LANE_W-1:0] din,
  input  logic [LANES-1:0]                  bw_n,
  output logic                              kphase,
  output logic [LANES*qdr4_pkg::LANE_W-1:0] dout,
  output logic                              dout_en,
  output logic                              echo
);
  import qdr4_pkg::*;
  localparam int DW  = LANES * LANE_W;
  localparam int WAW = AW + BEAT_W;

  phase_e ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= PH_K;
    else        ph <= (ph == PH_K) ? PH_KBAR : PH_K;
  end
  assign kphase = (ph == PH_K);

  logic           rd_accept, rd_fire;
  logic [WAW-1:0] rd_waddr;
  logic           wr_accept, wr_fire;
  logic [WAW-1:0] wr_waddr;
  logic [DW-1:0]  mem_q;
  logic [DW-1:0]  rd_word;
  logic           fwd_hit;

  qdr4_burst_seq #(.AW(AW)) u_rd_seq (
    .clk(clk), .rst_n(rst_n), .k_edge(kphase), .req_n(rd_n), .addr(addr),
    .accept(rd_accept), .fire(rd_fire), .word_addr(rd_waddr)
  );

  qdr4_burst_seq #(.AW(AW)) u_wr_seq (
    .clk(clk), .rst_n(rst_n), .k_edge(kphase), .req_n(wr_n), .addr(addr),
    .accept(wr_accept), .fire(wr_fire), .word_addr(wr_waddr)
  );

  qdr4_mem #(.WAW(WAW), .LANES(LANES)) u_mem (
    .clk(clk), .we(wr_fire), .waddr(wr_waddr), .wdata(din), .wbyte_n(bw_n),
    .raddr(rd_waddr), .rdata(mem_q)
  );

  function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old_w,
                                               input logic [DW-1:0] new_w,
                                               input logic [LANES-1:0] en_n);
    logic [DW-1:0] r;
    r = old_w;
    for (int i = 0; i < LANES; i++) begin
      if (!en_n[i]) r[i*LANE_W +: LANE_W] = new_w[i*LANE_W +: LANE_W];
    end
    return r;
  endfunction

  assign fwd_hit = wr_fire && (wr_waddr == rd_waddr);
  assign rd_word = fwd_hit ? lane_merge(mem_q, din, bw_n) : mem_q;

  qdr4_rd_out #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .fire(rd_fire), .word(rd_word),
    .dout(dout), .dout_en(dout_en), .echo(echo)
  );

  AST_PHASE_ALT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (ph != $past(ph))); // R1
  AST_READ_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_en) |-> $past(rd_accept, 3)); // R2
  AST_WRITE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_fire) |-> $past(wr_accept, 2)); // R3
endmodule

// File: tb/qdr4_sram_tb.sv
`timescale 1ns/1ps
module qdr4_sram_tb;
  localparam int AW = 4, LANES = 2, LW = 9, DW = LANES * LW, WORDS = (1 << AW) * 4;

  logic clk = 1'b0, rst_n = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [LANES-1:0] bw_n = '1;
  logic kphase, dout_en, echo;
  logic [DW-1:0] dout;

  always #5 clk = ~clk;

  qdr4_sram #(.AW(AW), .LANES(LANES)) u_dut (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .din(din),
    .bw_n(bw_n), .kphase(kphase), .dout(dout), .dout_en(dout_en), .echo(echo)
  );

  int checks = 0, errors = 0, n = 0, last_rd = -100, last_wr = -100;
  bit done = 0;
  string cur = "R11";
  logic [DW-1:0] ref_mem [WORDS];
  bit ring_rv [8], ring_wv [8];
  int ring_ra [8], ring_wa [8];
  bit exp_echo = 0;
  logic [31:0] rs = 32'h1234_5678;

  function automatic logic [31:0] nxt(input logic [31:0] x);
    logic [31:0] y = x;
    y ^= y << 13; y ^= y >> 17; y ^= y << 5;
    return y;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s [%s] tick %0d got %0h exp %0h", tag, cur, n, got, exp);
    end
  endtask

  task automatic step(input logic r, input logic w, input logic [AW-1:0] a,
                      input logic [LANES-1:0] b);
    bit ke, een;
    logic [DW-1:0] ed;
    ke = (n % 2 == 0);
    check("R1", 32'(kphase), 32'(ke));
    rs = nxt(rs);
    rd_n = r; wr_n = w; addr = a; bw_n = b; din = rs[DW-1:0];
    if (ke && !r && n - last_rd >= 4) begin
      last_rd = n;
      for (int k = 0; k < 4; k++) begin
        ring_rv[(n+2+k)%8] = 1; ring_ra[(n+2+k)%8] = a * 4 + k;
      end
    end
    if (ke && !w && n - last_wr >= 4) begin
      last_wr = n;
      for (int k = 0; k < 4; k++) begin
        ring_wv[(n+2+k)%8] = 1; ring_wa[(n+2+k)%8] = a * 4 + k;
      end
    end
    if (ring_wv[n%8]) begin
      for (int l = 0; l < LANES; l++)
        if (!b[l]) ref_mem[ring_wa[n%8]][l*LW +: LW] = din[l*LW +: LW];
      ring_wv[n%8] = 0;
    end
    een = ring_rv[n%8];
    ed = een ? ref_mem[ring_ra[n%8]] : '0;
    ring_rv[n%8] = 0;
    if (een) exp_echo = ~exp_echo;
    @(negedge clk);
    check(een ? "R2" : "R8", 32'(dout_en), 32'(een));
    check(een ? "R2" : "R8", 32'(dout), 32'(ed));
    check("R10", 32'(echo), 32'(exp_echo));
    n++;
  endtask

  task automatic idle(input int cnt);
    for (int i = 0; i < cnt; i++) step(1, 1, '0, '1);
  endtask

  task automatic align();
    if (n % 2 != 0) idle(1);
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) ref_mem[i] = '0;
    for (int i = 0; i < 8; i++) begin ring_rv[i] = 0; ring_wv[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11", 32'(dout_en), 0);
    check("R11", 32'(dout), 0);
    check("R11", 32'(echo), 0);
    rst_n = 1'b1;
    check("R11", 32'(dout_en), 0);

    cur = "R3";
    for (int a = 0; a < 16; a++) begin
      step(1, 0, AW'(a), '0); idle(3);
    end
    idle(4);

    cur = "R7";
    for (int a = 0; a < 16; a++) begin
      step(0, 1, AW'(15 - a), '1); idle(3);
    end
    for (int a = 0; a < 8; a++) begin
      step(1, 0, AW'(a), '0); idle(3);
    end
    idle(6);

    cur = "R5";
    align();
    step(0, 0, 4'd3, '0); idle(1); step(0, 0, 4'd9, '0); idle(1);
    idle(6);
    step(0, 1, 4'd9, '1); idle(3); step(0, 1, 4'd3, '1); idle(7);

    cur = "R1";
    align();
    idle(1); step(0, 0, 4'd7, '0); idle(1); step(0, 0, 4'd7, '0); idle(4);
    step(0, 1, 4'd7, '1); idle(7);

    cur = "R4";
    step(1, 0, 4'd2, 2'b11); step(1, 1, '0, 2'b00);
    step(1, 1, '0, 2'b01); step(1, 1, '0, 2'b10);
    step(1, 1, '0, 2'b11); step(1, 1, '0, 2'b00);
    idle(2); step(0, 1, 4'd2, '1); idle(7);

    cur = "R6";
    for (int i = 0; i < 12; i++) step(1, 1, AW'(i), '0);
    step(0, 1, 4'd2, '1); idle(3); step(0, 1, 4'd5, '1); idle(7);

    cur = "R9";
    step(0, 0, 4'd10, 2'b10); idle(1);
    step(1, 1, '0, 2'b01); step(1, 1, '0, 2'b10);
    step(0, 0, 4'd11, 2'b00); step(1, 1, '0, 2'b11);
    step(1, 1, '0, 2'b01); step(1, 1, '0, 2'b00);
    idle(8);

    cur = "R2";
    for (int i = 0; i < 3000; i++) begin
      rs = nxt(rs);
      step(rs[3], rs[7], rs[AW+11:12], rs[21:20]);
    end
    idle(8);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog [%s] run did not complete", cur);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule